// File: doc/BRIEF.md
# Complementary PWM Timer with Deadband

This block generates a pulse-width-modulated signal together with its complement. The timer clock is divided by a selectable power of two. A 16-bit up-counter runs from 1 to a programmed reload value and then starts again, with a one-clock reload pulse each time it wraps. When the counter equals a programmed match value, the primary output goes to the polarity level. When the counter reloads, the primary output goes to the opposite level. The complementary output follows the inverse of the primary.

To keep the two outputs from overlapping, each rising transition of either output is held back by a programmable number of system clock cycles. Every falling transition takes effect at once. If a held-back rise is overtaken by the next change before it completes, that rise is dropped. Clearing the enable parks both outputs at their inactive levels and restarts the prescaler and the counter.

Top module: `pwm_dt_timer`

## Requirements
- R1: While enabled, the counter advances once every 2^pres_sel clock cycles (pres_sel 0..7 gives division by 1..128). After an enable, the first advance falls on the 2^pres_sel-th clock edge.
- R2: While en is low the prescaler is held at zero, so after any re-enable the division restarts from its beginning.
- R3: After an enable the counter value is 1. On an advance where the counter is at or above reload_val, the counter returns to 1 and reload_pulse is high for the following clock cycle.
- R4: On an advance where the counter equals match_val, the primary output level becomes pol. On a reload advance it becomes the inverse of pol. Reload wins when both occur on the same advance.
- R5: pwm_out_n carries the inverse of the primary level, and pwm_out and pwm_out_n are never high in the same cycle.
- R6: A rise of either output appears dead_cyc clock cycles after it would appear with no deadband. A fall appears one clock after the level change, and dead_cyc = 0 adds no delay.
- R7: A pending rise whose requested level drops before the delay ends is cancelled, and the output stays low.
- R8: One clock after en is sampled low, pwm_out equals the inverse of pol and pwm_out_n equals pol. Synchronous reset drives both outputs and reload_pulse low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Timer enable |
| pres_sel | input | 3 | Prescale exponent, divide by 2^pres_sel |
| pol | input | 1 | Level the primary output takes on a match |
| reload_val | input | 16 | Terminal count of the period |
| match_val | input | 16 | Count at which the primary output goes to pol |
| dead_cyc | input | 8 | Rising-edge delay in clock cycles |
| pwm_out | output | 1 | Primary PWM output |
| pwm_out_n | output | 1 | Complementary PWM output |
| reload_pulse | output | 1 | One-clock pulse after each counter wrap |

## Verification
Some properties are checked on every cycle: the prescaler is clear after a disabled cycle, the counter is back at 1 whenever the reload pulse is seen, falls take effect at once, the two outputs never overlap, and the idle levels hold while disabled. The exact placement of edges needs the bench's cycle model: the prescaled period, the match-versus-reload priority, the length of the deadband delay, and the cancellation of short pulses. The bench compares every output on every cycle across several prescale, polarity and deadband settings, and counts reload pulses over fixed windows.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

    localparam int CNT_W  = 16;
    localparam int PRES_W = 3;
    localparam int DB_W   = 8;

    // Events produced by the counter on one prescaled advance
    typedef struct packed {
        logic tick;
        logic at_match;
        logic at_reload;
    } evt_t;

    // Last prescaler state for a given exponent: 2^sel - 1
    function automatic logic [(1<<PRES_W)-2:0] pres_last(input logic [PRES_W-1:0] sel);
        logic [(1<<PRES_W)-2:0] one;
        one = '0;
        one[0] = 1'b1;
        return (one << sel) - one;
    endfunction

endpackage

// File: rtl/pwm_dt_prescaler.sv
module pwm_dt_prescaler
    import pwm_dt_pkg::*;
#(
    parameter int PW = PRES_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [PW-1:0] sel,
    output logic          tick_o
);
    localparam int DIV_W = (1 << PW) - 1;

    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] last;

    always_comb begin
        last   = DIV_W'(pres_last(PRES_W'(sel)));
        tick_o = en && (pcnt == last);
    end

    always_ff @(posedge clk) begin
        if (rst || !en || tick_o)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end

    p_pres_clear_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pcnt == '0));

endmodule

// File: rtl/pwm_dt_counter.sv
module pwm_dt_counter
    import pwm_dt_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          tick,
    input  logic          pol,
    input  logic [CW-1:0] reload_val,
    input  logic [CW-1:0] match_val,
    output logic          raw_o,
    output logic          reload_o
);
    localparam logic [CW-1:0] START = CW'(1);

    logic [CW-1:0] cnt;
    evt_t          ev;

    always_comb begin
        ev.tick      = tick;
        ev.at_reload = tick && (cnt >= reload_val);
        ev.at_match  = tick && (cnt == match_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= START;
            raw_o    <= 1'b0;
            reload_o <= 1'b0;
        end else if (!en) begin
            cnt      <= START;
            raw_o    <= ~pol;
            reload_o <= 1'b0;
        end else begin
            reload_o <= ev.at_reload;
            if (ev.at_reload) begin
                cnt   <= START;
                raw_o <= ~pol;
            end else begin
                if (ev.tick)
                    cnt <= cnt + 1'b1;
                if (ev.at_match)
                    raw_o <= pol;
            end
        end
    end

    p_reload_restart_r3: assert property (@(posedge clk) disable iff (rst)
        reload_o |-> (cnt == START));

endmodule

// File: rtl/pwm_dt_deadband.sv
module pwm_dt_deadband
    import pwm_dt_pkg::*;
#(
    parameter int DW = DB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frc,
    input  logic          frc_val,
    input  logic          want,
    input  logic [DW-1:0] dead,
    output logic          q
);
    logic [DW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= 1'b0;
            wait_cnt <= '0;
        end else if (frc) begin
            q        <= frc_val;
            wait_cnt <= '0;
        end else if (!want) begin
            q        <= 1'b0;           // fall at once, drop any pending rise
            wait_cnt <= '0;
        end else if (q) begin
            wait_cnt <= '0;
        end else if (wait_cnt == dead) begin
            q        <= 1'b1;
            wait_cnt <= '0;
        end else begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    p_fall_now_r6: assert property (@(posedge clk) disable iff (rst)
        (!frc && !want) |=> !q);

    p_cancel_r7: assert property (@(posedge clk) disable iff (rst)
        (!frc && !want && !q) |=> (wait_cnt == '0));

endmodule

// File: rtl/pwm_dt_timer.sv
module pwm_dt_timer
    import pwm_dt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PRES_W,
    parameter int DW = DB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [PW-1:0] pres_sel,
    input  logic          pol,
    input  logic [CW-1:0] reload_val,
    input  logic [CW-1:0] match_val,
    input  logic [DW-1:0] dead_cyc,
    output logic          pwm_out,
    output logic          pwm_out_n,
    output logic          reload_pulse
);
    localparam int NOUT = 2;

    logic            tick;
    logic            raw;
    logic [NOUT-1:0] want_v;
    logic [NOUT-1:0] idle_v;
    logic [NOUT-1:0] q_v;

    pwm_dt_prescaler #(.PW(PW)) u_pres (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .sel    (pres_sel),
        .tick_o (tick)
    );

    pwm_dt_counter #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .tick       (tick),
        .pol        (pol),
        .reload_val (reload_val),
        .match_val  (match_val),
        .raw_o      (raw),
        .reload_o   (reload_pulse)
    );

    // Index 0 is the primary output, index 1 the complement
    for (genvar g = 0; g < NOUT; g++) begin : g_out
        assign want_v[g] = (g == 0) ? raw  : ~raw;
        assign idle_v[g] = (g == 0) ? ~pol : pol;

        pwm_dt_deadband #(.DW(DW)) u_db (
            .clk     (clk),
            .rst     (rst),
            .frc     (!en),
            .frc_val (idle_v[g]),
            .want    (want_v[g]),
            .dead    (dead_cyc),
            .q       (q_v[g])
        );
    end

    assign pwm_out   = q_v[0];
    assign pwm_out_n = q_v[1];

    p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
        !(pwm_out && pwm_out_n));

    p_idle_levels_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pwm_out == !$past(pol)) && (pwm_out_n == $past(pol)));

endmodule

// File: tb/pwm_dt_timer_tb.sv
module pwm_dt_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [2:0]  pres_sel = '0;
    logic        pol = 1'b1;
    logic [15:0] reload_val = 16'd5;
    logic [15:0] match_val = 16'd3;
    logic [7:0]  dead_cyc = '0;
    logic        pwm_out, pwm_out_n, reload_pulse;

    int    vecs = 0;
    int    errs = 0;
    int    cyc = 0;
    string cur_req = "R8";
    bit    done = 0;

    // reference model state
    int m_pc = 0, m_cnt = 1;
    bit m_raw = 0, m_rp = 0;
    bit m_q[2] = '{0, 0};
    int m_w[2] = '{0, 0};

    always #4 clk = ~clk;   // 125 MHz

    pwm_dt_timer u_dut (
        .clk(clk), .rst(rst), .en(en), .pres_sel(pres_sel), .pol(pol),
        .reload_val(reload_val), .match_val(match_val), .dead_cyc(dead_cyc),
        .pwm_out(pwm_out), .pwm_out_n(pwm_out_n), .reload_pulse(reload_pulse)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_pc = 0; m_cnt = 1; m_raw = 0; m_rp = 0;
            for (int i = 0; i < 2; i++) begin m_q[i] = 0; m_w[i] = 0; end
        end else begin
            bit tick, rel, mat;
            bit want[2];
            bit idle[2];
            int lim;
            lim  = (1 << pres_sel) - 1;
            tick = en && (m_pc == lim);
            rel  = tick && (m_cnt >= reload_val);
            mat  = tick && (m_cnt == match_val);
            want[0] = m_raw; want[1] = !m_raw;
            idle[0] = !pol;  idle[1] = pol;
            for (int i = 0; i < 2; i++) begin
                if (!en) begin m_q[i] = idle[i]; m_w[i] = 0; end
                else if (!want[i]) begin m_q[i] = 0; m_w[i] = 0; end
                else if (m_q[i]) m_w[i] = 0;
                else if (m_w[i] == dead_cyc) begin m_q[i] = 1; m_w[i] = 0; end
                else m_w[i] = m_w[i] + 1;
            end
            m_pc = (!en || tick) ? 0 : m_pc + 1;
            m_rp = en && rel;
            if (!en) begin m_cnt = 1; m_raw = !pol; end
            else if (rel) begin m_cnt = 1; m_raw = !pol; end
            else begin
                if (tick) m_cnt = m_cnt + 1;
                if (mat) m_raw = pol;
            end
        end
    end

    task automatic chk(string what, logic act, bit exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", cur_req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!done) begin
            chk("pwm_out", pwm_out, m_q[0]);
            chk("pwm_out_n", pwm_out_n, m_q[1]);
            chk("reload_pulse", reload_pulse, m_rp);
        end
        if (cyc > 100000 && !done) begin
            errs++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_pulses(int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (reload_pulse) c++;
        end
    endtask

    task automatic expect_int(string req, string what, int act, int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        int c;
        int highs;
        cur_req = "R8";
        run(3);
        expect_int("R8", "reset pwm_out", int'(pwm_out), 0);
        expect_int("R8", "reset pwm_out_n", int'(pwm_out_n), 0);
        rst = 1'b0;
        run(3);   // disabled, idle levels compared by the model

        // R3: pres 0, reload 10, fresh enable -> 10 pulses in 100 edges
        cur_req = "R3";
        pres_sel = 3'd0; reload_val = 16'd10; match_val = 16'd4;
        en = 1'b1;
        count_pulses(100, c);
        expect_int("R3", "reload pulses at div1", c, 10);
        en = 1'b0; run(4);

        // R1: div 4, reload 5 -> first pulse at edge 20, 5 pulses in 100 edges
        cur_req = "R1";
        pres_sel = 3'd2; reload_val = 16'd5; match_val = 16'd3;
        en = 1'b1;
        count_pulses(100, c);
        expect_int("R1", "reload pulses at div4", c, 5);
        pres_sel = 3'd3; run(200);
        pres_sel = 3'd7; reload_val = 16'd2; match_val = 16'd1; run(600);
        en = 1'b0; run(3);

        // R2: disable mid-prescale, re-enable
        cur_req = "R2";
        pres_sel = 3'd2; reload_val = 16'd4; match_val = 16'd2;
        en = 1'b1; run(6);
        en = 1'b0; run(3);
        en = 1'b1; run(50);
        en = 1'b0; run(2);

        // R4: inverted polarity, match equal to reload, then earlier match
        cur_req = "R4";
        pol = 1'b0; pres_sel = 3'd0; reload_val = 16'd4; match_val = 16'd4;
        en = 1'b1; run(40);
        match_val = 16'd2; run(40);
        en = 1'b0; run(3);

        // R6: deadband on rising edges
        cur_req = "R6";
        pol = 1'b1; pres_sel = 3'd1; reload_val = 16'd20; match_val = 16'd8;
        dead_cyc = 8'd3;
        en = 1'b1; run(200);
        dead_cyc = 8'd0; run(100);
        en = 1'b0; run(3);

        // R5: complement and non-overlap with small deadband
        cur_req = "R5";
        pres_sel = 3'd0; reload_val = 16'd12; match_val = 16'd5; dead_cyc = 8'd2;
        en = 1'b1; run(100);
        en = 1'b0; run(3);

        // R7: pulses shorter than the deadband are dropped
        cur_req = "R7";
        pres_sel = 3'd0; reload_val = 16'd8; match_val = 16'd4; dead_cyc = 8'd6;
        en = 1'b1; run(10);
        highs = 0;
        repeat (80) begin
            @(negedge clk);
            if (pwm_out) highs++;
        end
        expect_int("R7", "primary highs while cancelled", highs, 0);
        en = 1'b0; run(3);

        // R8: idle levels with each polarity
        cur_req = "R8";
        pol = 1'b0; run(3);
        expect_int("R8", "idle pwm_out pol0", int'(pwm_out), 1);
        expect_int("R8", "idle pwm_out_n pol0", int'(pwm_out_n), 0);
        pol = 1'b1; run(3);
        expect_int("R8", "idle pwm_out pol1", int'(pwm_out), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule